// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block decides whether a store-exclusive may write memory. A load-exclusive request forms an effective address from a base value, an immediate offset and an access size, and records that address and size as the one reservation held for the processor. A later store-exclusive forms its own address the same way. It writes memory only when the reservation is still valid and both address and size agree. The outcome comes back as a status word: 0 when the write was performed and 1 when it was not.

A snoop port reports writes made by other bus agents. A snooped write that lands in the same aligned word as the reserved address cancels the reservation, so a success status always means no other agent wrote that word in between. Every request answers one cycle later on a registered response interface. That interface carries the effective address, a read strobe for loads, a write-enable for stores, the status word and an illegal-encoding flag.

Top module: `excl_monitor`

## Requirements
- R1: `req_size` encodes the access width as 0 = byte, 1 = halfword, 2 = word; the value 3 is an illegal encoding and raises `rsp_illegal`.
- R2: For word accesses the effective address is `req_base + req_offset`; an offset that is not a multiple of 4 or exceeds 1020 raises `rsp_illegal`. An illegal request asserts neither `rsp_rd` nor `rsp_we`, returns status 1 for a store, and leaves the reservation unchanged.
- R3: For byte and halfword accesses the effective address is `req_base`; a non-zero offset raises `rsp_illegal`.
- R4: A legal load-exclusive asserts `rsp_rd` with `rsp_addr` equal to its effective address and status 0. It replaces any earlier reservation with its own address and size.
- R5: A legal store-exclusive asserts `rsp_we` with status 0 exactly when a valid reservation exists whose address equals its full effective address and whose size equals its size.
- R6: Any other store-exclusive (no reservation, different address or different size) returns status 1 with `rsp_we` low.
- R7: Every legal store-exclusive clears the reservation, whether it succeeds or fails.
- R8: A snooped write whose address falls in the same aligned 4-byte word as the reservation clears it at the next clock edge. A snoop hit in the same cycle as a store-exclusive makes that store fail. A load-exclusive in the same cycle as a snoop hit still installs its reservation.
- R9: All response outputs are registered. `rsp_valid` is high in exactly the cycle after each request, and `rsp_status` holds only the values 0 or 1.
- R10: After reset there is no reservation and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An exclusive request is presented this cycle |
| req_store | input | 1 | 1 = store-exclusive, 0 = load-exclusive |
| req_base | input | AW | Base address value |
| req_offset | input | OFFW | Immediate byte offset |
| req_size | input | 2 | Access size (R1) |
| snoop_valid | input | 1 | A write by another agent is reported |
| snoop_addr | input | AW | Address of the snooped write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rd | output | 1 | Load-exclusive performed |
| rsp_we | output | 1 | Write-enable toward memory for a store-exclusive |
| rsp_illegal | output | 1 | Request had an illegal size/offset encoding |
| rsp_addr | output | AW | Effective address of the request |
| rsp_status | output | STW | Store status: 0 written, 1 not written |

## Verification
The success decision is tried with matched pairs, then with a store whose address differs by one byte, a store whose size differs, a store with no prior load and a second store after a success. These separate the address, size and clear-on-store terms of the decision. Snoops are applied to the reserved word at a different byte lane, to the adjacent word, and in the same cycle as a store or a load; this separates word-granular matching and the same-cycle priorities. Offsets of 2, 1020, 1024 and a non-zero byte offset, plus size 3, separate the legality rules. A mixed stream over a small address pool then exercises interleavings against a behavioural reservation model.

// File: rtl/excl_pkg.sv
// Package: shared types for the exclusive reservation monitor.
// Assumes: sizes are encoded in two bits; the top encoding is reserved.
package excl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      valid;
        acc_size_e size;
    } resv_tag_t;

endpackage

// File: rtl/excl_agu.sv
// Module: excl_agu
// Forms the effective address of an exclusive request and checks that its
// size and immediate offset form a legal encoding.
// Assumes: AW > OFFW; OFF_ALIGN is a power of two of at least 2.
module excl_agu
    import excl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int OFFW      = 12,
    parameter int MAX_OFF   = 1020,
    parameter int OFF_ALIGN = 4
) (
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] offset,
    input  acc_size_e       size,
    output logic [AW-1:0]   eff_addr,
    output logic            legal
);

    localparam int ALIGN_BITS = $clog2(OFF_ALIGN);
    localparam logic [OFFW-1:0] MAX_OFF_V = OFFW'(MAX_OFF);

    logic [AW-1:0] off_ext;
    logic          off_aligned;
    logic          off_in_range;
    logic          off_zero;

    // Purpose: classify the offset (alignment, range, zero).
    always_comb begin
        off_ext      = {{(AW-OFFW){1'b0}}, offset};
        off_aligned  = (offset[ALIGN_BITS-1:0] == '0);
        off_in_range = (offset <= MAX_OFF_V);
        off_zero     = (offset == '0);
    end

    // Purpose: pick the address form and legality rule by access size.
    always_comb begin
        unique case (size)
            SZ_WORD: begin
                eff_addr = base + off_ext;
                legal    = off_aligned && off_in_range;
            end
            SZ_BYTE, SZ_HALF: begin
                eff_addr = base;
                legal    = off_zero;
            end
            default: begin
                eff_addr = base;
                legal    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/excl_resv.sv
// Module: excl_resv
// Holds the single reservation (address and size), evaluates a store match
// and cancels the reservation on stores or on snooped writes to its word.
// Assumes: at most one of set_en / clr_en is high in a cycle.
module excl_resv
    import excl_pkg::*;
#(
    parameter int AW       = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [AW-1:0] req_addr,
    input  acc_size_e     req_size,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          match,
    output logic          holding
);

    localparam logic [AW-1:0] WORD_MASK = ~((AW'(1) << GRAN_LSB) - AW'(1));

    resv_tag_t     tag_q;
    logic [AW-1:0] addr_q;
    logic          snoop_hit;

    // Purpose: detect a snooped write into the reserved word.
    always_comb begin
        snoop_hit = snoop_valid && tag_q.valid &&
                    ((snoop_addr & WORD_MASK) == (addr_q & WORD_MASK));
    end

    // Purpose: decide whether the presented store agrees with the reservation.
    always_comb begin
        match = tag_q.valid && !snoop_hit &&
                (addr_q == req_addr) && (tag_q.size == req_size);
    end

    // Purpose: install, clear or keep the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '{valid: 1'b0, size: SZ_BYTE};
            addr_q <= '0;
        end else if (set_en) begin
            tag_q  <= '{valid: 1'b1, size: req_size};
            addr_q <= req_addr;
        end else if (clr_en || snoop_hit) begin
            tag_q.valid <= 1'b0;
        end
    end

    assign holding = tag_q.valid;

endmodule

// File: rtl/excl_resp.sv
// Module: excl_resp
// Registers the response of each request so it is seen one cycle later.
// Assumes: the decision inputs are stable in the request cycle.
module excl_resp #(
    parameter int AW  = 32,
    parameter int STW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_store,
    input  logic           legal,
    input  logic           match,
    input  logic [AW-1:0]  eff_addr,
    output logic           rsp_valid,
    output logic           rsp_rd,
    output logic           rsp_we,
    output logic           rsp_illegal,
    output logic [AW-1:0]  rsp_addr,
    output logic [STW-1:0] rsp_status
);

    logic do_write;
    logic do_read;
    logic st_fail;

    // Purpose: derive the outcome of the current request.
    always_comb begin
        do_write = req_valid && req_store && legal && match;
        do_read  = req_valid && !req_store && legal;
        st_fail  = req_valid && req_store && !do_write;
    end

    // Purpose: register strobes, flags and status for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rd      <= 1'b0;
            rsp_we      <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_status  <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_rd      <= do_read;
            rsp_we      <= do_write;
            rsp_illegal <= req_valid && !legal;
            rsp_status  <= STW'(st_fail);
        end
    end

    // Purpose: capture the effective address of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
        end else if (req_valid) begin
            rsp_addr <= eff_addr;
        end
    end

endmodule

// File: rtl/excl_monitor.sv
// Module: excl_monitor (top)
// Exclusive access reservation monitor: address generation, legality check,
// single reservation with snoop cancellation, registered store status.
// Assumes: one request per cycle; snoop reports writes by other agents only.
module excl_monitor
    import excl_pkg::*;
#(
    parameter int AW        = 32,
    parameter int OFFW      = 12,
    parameter int MAX_OFF   = 1020,
    parameter int OFF_ALIGN = 4,
    parameter int STW       = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_store,
    input  logic [AW-1:0]  req_base,
    input  logic [OFFW-1:0] req_offset,
    input  logic [1:0]     req_size,
    input  logic           snoop_valid,
    input  logic [AW-1:0]  snoop_addr,
    output logic           rsp_valid,
    output logic           rsp_rd,
    output logic           rsp_we,
    output logic           rsp_illegal,
    output logic [AW-1:0]  rsp_addr,
    output logic [STW-1:0] rsp_status
);

    localparam int GRAN_LSB = $clog2(OFF_ALIGN);

    acc_size_e     size_e;
    logic [AW-1:0] eff_addr;
    logic          legal;
    logic          match;
    logic          set_en;
    logic          clr_en;
    logic          holding;

    // Purpose: decode the size field and the reservation controls.
    always_comb begin
        size_e = acc_size_e'(req_size);
        set_en = req_valid && !req_store && legal;
        clr_en = req_valid && req_store && legal;
    end

    excl_agu #(
        .AW(AW), .OFFW(OFFW), .MAX_OFF(MAX_OFF), .OFF_ALIGN(OFF_ALIGN)
    ) i_agu (
        .base(req_base), .offset(req_offset), .size(size_e),
        .eff_addr(eff_addr), .legal(legal)
    );

    excl_resv #(
        .AW(AW), .GRAN_LSB(GRAN_LSB)
    ) i_resv (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
        .req_addr(eff_addr), .req_size(size_e),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .match(match), .holding(holding)
    );

    excl_resp #(
        .AW(AW), .STW(STW)
    ) i_resp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .legal(legal), .match(match), .eff_addr(eff_addr),
        .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_we(rsp_we),
        .rsp_illegal(rsp_illegal), .rsp_addr(rsp_addr), .rsp_status(rsp_status)
    );

endmodule

// File: rtl/excl_monitor_chk.sv
// Module: excl_monitor_chk
// Temporal checks on the monitor's ports, attached by bind.
// Assumes: rst_n is synchronous and active low.
module excl_monitor_chk #(
    parameter int STW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_store,
    input logic           rsp_valid,
    input logic           rsp_rd,
    input logic           rsp_we,
    input logic           rsp_illegal,
    input logic [STW-1:0] rsp_status
);

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    status_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status >> 1) == '0);

    // R5
    write_means_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |-> (rsp_status == '0) && rsp_valid);

    // R5
    write_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |-> $past(req_valid && req_store));

    // R2
    illegal_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> !rsp_we && !rsp_rd);

    // R4
    load_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd |-> (rsp_status == '0) && !rsp_we);

    // R7
    no_back_to_back_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |=> !rsp_we);

endmodule

bind excl_monitor excl_monitor_chk #(.STW(STW)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_we(rsp_we),
    .rsp_illegal(rsp_illegal), .rsp_status(rsp_status)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        rsp_valid, rsp_rd, rsp_we, rsp_illegal;
    logic [31:0] rsp_addr;
    logic [31:0] rsp_status;

    int checks = 0;
    int fails  = 0;

    // reference reservation
    bit          m_valid = 0;
    logic [31:0] m_addr  = '0;
    int          m_size  = 0;

    always #5 clk = ~clk;

    excl_monitor i_excl_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_we(rsp_we),
        .rsp_illegal(rsp_illegal), .rsp_addr(rsp_addr), .rsp_status(rsp_status)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual=expired expected=done");
        summary();
        $finish;
    end

    // One cycle: drive at negedge, predict, compare at the following negedge.
    task automatic step(input string tag, input bit v, input bit st,
                        input logic [31:0] base, input int off, input int sz,
                        input bit sv = 0, input logic [31:0] sa = '0);
        bit legal, hit, ok;
        logic [31:0] ea;
        bit e_rd, e_we, e_ill;
        int e_stat;
        bit bad;
        req_valid = v; req_store = st; req_base = base;
        req_offset = 12'(off); req_size = 2'(sz);
        snoop_valid = sv; snoop_addr = sa;
        legal = (sz == 2) ? ((off % 4 == 0) && off <= 1020)
                          : ((sz == 0 || sz == 1) && off == 0);
        ea    = (sz == 2) ? base + 32'(off) : base;
        hit   = sv && m_valid && ((sa >> 2) == (m_addr >> 2));
        ok    = m_valid && !hit && m_addr == ea && m_size == sz;
        e_rd  = v && !st && legal;
        e_we  = v && st && legal && ok;
        e_ill = v && !legal;
        e_stat = (v && st && !e_we) ? 1 : 0;
        if (v && legal && !st) begin
            m_valid = 1; m_addr = ea; m_size = sz;
        end else if ((v && legal && st) || hit) begin
            m_valid = 0;
        end
        @(negedge clk);
        checks++;
        bad = (rsp_valid !== v) || (rsp_rd !== e_rd) || (rsp_we !== e_we) ||
              (rsp_illegal !== e_ill) || (rsp_status !== 32'(e_stat)) ||
              (v && rsp_addr !== ea);
        if (bad) begin
            fails++;
            $display("FAIL %s: actual v=%0b rd=%0b we=%0b ill=%0b st=%0d a=%h expected v=%0b rd=%0b we=%0b ill=%0b st=%0d a=%h",
                     tag, rsp_valid, rsp_rd, rsp_we, rsp_illegal, rsp_status, rsp_addr,
                     v, e_rd, e_we, e_ill, e_stat, ea);
        end
        req_valid = 0; snoop_valid = 0;
    endtask

    task automatic ld(input string tag, input logic [31:0] b, input int o, input int s,
                      input bit sv = 0, input logic [31:0] sa = '0);
        step(tag, 1, 0, b, o, s, sv, sa);
    endtask

    task automatic stx(input string tag, input logic [31:0] b, input int o, input int s,
                       input bit sv = 0, input logic [31:0] sa = '0);
        step(tag, 1, 1, b, o, s, sv, sa);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (rsp_valid || rsp_rd || rsp_we || rsp_illegal || rsp_status != 0 || rsp_addr != 0) begin
            fails++;
            $display("FAIL R10: actual v=%0b we=%0b st=%0d expected all zero",
                     rsp_valid, rsp_we, rsp_status);
        end
        rst_n = 1'b1;
        @(negedge clk);

        stx("R10_no_resv_after_reset", 32'h1000, 0, 2);
        stx("R6_no_resv", 32'h1000, 8, 2);
        ld ("R4_load_word", 32'h1000, 8, 2);
        stx("R5_match_word", 32'h1000, 8, 2);
        stx("R7_second_store", 32'h1000, 8, 2);
        step("R9_idle", 0, 0, 0, 0, 0);

        ld ("R3_load_byte", 32'h2001, 0, 0);
        stx("R6_size_mismatch", 32'h2001, 0, 1);
        ld ("R3_load_byte", 32'h2001, 0, 0);
        stx("R6_addr_mismatch", 32'h2002, 0, 0);
        ld ("R1_load_half", 32'h2002, 0, 1);
        stx("R1_store_half", 32'h2002, 0, 1);
        ld ("R1_load_byte", 32'h2003, 0, 0);
        stx("R1_store_byte", 32'h2003, 0, 0);

        ld ("R2_off_misaligned", 32'h3000, 6, 2);
        ld ("R2_off_too_big", 32'h3000, 1024, 2);
        ld ("R2_off_max", 32'h3000, 1020, 2);
        stx("R2_store_off_max", 32'h3000, 1020, 2);
        ld ("R3_byte_with_offset", 32'h3000, 4, 0);
        ld ("R1_size_rsvd", 32'h3000, 0, 3);
        stx("R1_store_size_rsvd", 32'h3000, 0, 3);
        ld ("R2_keep_resv", 32'h3000, 0, 2);
        ld ("R2_illegal_load", 32'h4000, 2, 2);
        stx("R2_illegal_store", 32'h3000, 2, 2);
        stx("R2_resv_unchanged", 32'h3000, 0, 2);

        ld ("R8_load", 32'h5000, 0, 2);
        step("R8_snoop_same_word", 0, 0, 0, 0, 0, 1, 32'h5003);
        stx("R8_store_after_snoop", 32'h5000, 0, 2);
        ld ("R8_load", 32'h5000, 0, 2);
        step("R8_snoop_next_word", 0, 0, 0, 0, 0, 1, 32'h5004);
        stx("R8_store_survives", 32'h5000, 0, 2);
        ld ("R8_load", 32'h5000, 0, 2);
        stx("R8_snoop_with_store", 32'h5000, 0, 2, 1, 32'h5001);
        ld ("R8_load", 32'h5000, 0, 2);
        ld ("R8_load_with_snoop", 32'h5000, 0, 2, 1, 32'h5000);
        stx("R8_load_wins", 32'h5000, 0, 2);

        ld ("R4_first", 32'h6000, 0, 2);
        ld ("R4_replace", 32'h7000, 0, 2);
        stx("R4_old_addr_fails", 32'h6000, 0, 2);
        ld ("R4_first", 32'h6000, 0, 2);
        ld ("R4_replace", 32'h7000, 0, 2);
        stx("R4_new_addr_wins", 32'h7000, 0, 2);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] pool [4] = '{32'h100, 32'h104, 32'h101, 32'h200};
            int offs [6] = '{0, 4, 8, 2, 1020, 1024};
            step("R5_R6_mixed", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 pool[$urandom_range(0, 3)], offs[$urandom_range(0, 5)],
                 $urandom_range(0, 3), $urandom_range(0, 3) == 0,
                 pool[$urandom_range(0, 3)] + 32'($urandom_range(0, 3)));
        end

        summary();
        $finish;
    end

endmodule